// File: doc/BRIEF.md
# Phase-Sequenced Dual-Channel PWM Generator

This block produces the gate signals for a two-input step-up power stage. A free-running counter sets the switching period in clock cycles. Channel A drives a pair of switches that always move together and are on at the start of each period. Channel B drives a third switch. Its on-time does not start at the period start. It starts at the moment channel A turns off, and it may run past the end of the period into the next one. When the two duties together exceed one period, all three switches are on together for a short interval at the start of each period.

The period length and the two duty words are given in clock cycles. They are captured only at period boundaries, so a pulse in progress is never cut short. An enable input starts the counter and stops it. By default both channels take their duty from the channel-A word. An independent mode lets channel B use its own word. With a 125 MHz clock, a period word of 1250 gives a 100 kHz switching frequency. Duties of 50 % to 85 % of the period are the main operating range, but any duty from zero up to full scale is accepted.

Top module: `phase_pwm_top`

## Requirements
- R1: `gate_a0` and `gate_a1` are identical on every cycle. Both are high for the first A cycles of each period, where A is the captured channel-A duty.
- R2: `gate_b` turns on at counter value A and stays on for B cycles, where B is the captured channel-B duty. The part that passes the period end continues in the next period.
- R3: When A + B exceeds the period length P, `gate_b` is also high for the first A + B − P cycles of the following period, so all three gates overlap there.
- R4: When `indep_duty` is 0, `duty_b` has no effect and channel B uses the channel-A duty word. When `indep_duty` is 1, channel B uses `duty_b`.
- R5: `period_start` is high for exactly one cycle, when the counter is 0. Each period lasts max(`period_len`, 2) cycles.
- R6: `period_len`, `duty_a`, `duty_b` and `indep_duty` are sampled only on the clock edge that begins a period. A change in the middle of a period takes effect at the next period.
- R7: In the first period after enable, the wrapped part of channel B is already present at the period start. Its length comes from that period's own captured values.
- R8: A duty of 0 holds its gate constantly low. A duty of at least P is clamped to P and holds its gate constantly high. Neither case produces a glitch pulse.
- R9: With `en` low at a clock edge, all gates and `period_start` are low after that edge and the wrap carry is cleared. Raising `en` again restarts the period at counter 0, beginning one cycle after `en` is first seen high.
- R10: While `rst` is high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off |
| period_len | input | 16 | Switching period in clock cycles (minimum 2 applied) |
| duty_a | input | 16 | Channel-A on-time in cycles |
| duty_b | input | 16 | Channel-B on-time in cycles (independent mode only) |
| indep_duty | input | 1 | 1: channel B uses `duty_b`; 0: both channels use `duty_a` |
| gate_a0 | output | 1 | Channel-A gate, first switch |
| gate_a1 | output | 1 | Channel-A gate, second switch |
| gate_b | output | 1 | Channel-B gate |
| period_start | output | 1 | One-cycle strobe at counter 0 |

## Verification
On every cycle the assertions check these points: the twin gates match, channel A rises only at a period start, channel B takes over the instant channel A falls inside a period, the gates are off after enable is lowered, and the start strobe never lasts two cycles. Other behaviour depends on values held across whole periods, and only the bench scenarios, compared against the reference model, can show it. This covers the exact overlap length when the duties wrap, the very first period after enable, the deferral of duty and period changes made mid-period, the single-duty mode ignoring the channel-B word, and the constant outputs at zero and full-scale duty.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

    localparam int unsigned CNT_W    = 16;
    localparam int unsigned MIN_PER  = 2;
    localparam int unsigned N_TWIN   = 2;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [CNT_W:0]   sum_t;

    typedef struct packed {
        cnt_t per;
        cnt_t on_a;
        cnt_t on_b;
    } pwm_cfg_t;

    // clamp period to the minimum and both duties to the period
    function automatic pwm_cfg_t sanitize(input pwm_cfg_t raw);
        pwm_cfg_t c;
        c.per  = (raw.per < cnt_t'(MIN_PER)) ? cnt_t'(MIN_PER) : raw.per;
        c.on_a = (raw.on_a > c.per) ? c.per : raw.on_a;
        c.on_b = (raw.on_b > c.per) ? c.per : raw.on_b;
        return c;
    endfunction

    // length of channel B's on-time that spills past the period end
    function automatic cnt_t spill(input pwm_cfg_t c);
        sum_t total;
        sum_t excess;
        total  = {1'b0, c.on_a} + {1'b0, c.on_b};
        excess = total - {1'b0, c.per};
        return (total > {1'b0, c.per}) ? excess[CNT_W-1:0] : '0;
    endfunction

endpackage

// File: rtl/pwm_cfg_timer.sv
module pwm_cfg_timer
    import pwm_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  pwm_cfg_t cfg_in,
    output logic     run,
    output cnt_t     cnt,
    output pwm_cfg_t cfg_act,
    output cnt_t     carry_len,
    output logic     pstart
);

    pwm_cfg_t cfg_new;
    logic     last_cyc;

    always_comb begin
        cfg_new  = sanitize(cfg_in);
        last_cyc = (cnt == (cfg_act.per - cnt_t'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run       <= 1'b0;
            cnt       <= '0;
            cfg_act   <= '0;
            carry_len <= '0;
        end else if (!run) begin
            // first period: spill taken from the values being loaded
            run       <= 1'b1;
            cnt       <= '0;
            cfg_act   <= cfg_new;
            carry_len <= spill(cfg_new);
        end else if (last_cyc) begin
            cnt       <= '0;
            cfg_act   <= cfg_new;
            carry_len <= spill(cfg_act);
        end else begin
            cnt       <= cnt + cnt_t'(1);
        end
    end

    assign pstart = run && (cnt == '0);

endmodule

// File: rtl/pwm_gate_decode.sv
module pwm_gate_decode
    import pwm_seq_pkg::*;
#(
    parameter int unsigned TWINS = N_TWIN
) (
    input  logic             run,
    input  cnt_t             cnt,
    input  pwm_cfg_t         cfg_act,
    input  cnt_t             carry_len,
    output logic [TWINS-1:0] gate_a,
    output logic             gate_b
);

    sum_t end_b;
    logic b_main;
    logic b_wrap;

    for (genvar g = 0; g < TWINS; g++) begin : g_twin
        assign gate_a[g] = run && (cnt < cfg_act.on_a);
    end

    always_comb begin
        end_b  = {1'b0, cfg_act.on_a} + {1'b0, cfg_act.on_b};
        b_main = (cnt >= cfg_act.on_a) && ({1'b0, cnt} < end_b);
        b_wrap = (cnt < carry_len);
        gate_b = run && (b_main || b_wrap);
    end

endmodule

// File: rtl/phase_pwm_top.sv
module phase_pwm_top
    import pwm_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period_len,
    input  logic [CNT_W-1:0] duty_a,
    input  logic [CNT_W-1:0] duty_b,
    input  logic             indep_duty,
    output logic             gate_a0,
    output logic             gate_a1,
    output logic             gate_b,
    output logic             period_start
);

    pwm_cfg_t           cfg_in;
    pwm_cfg_t           cfg_act;
    cnt_t               cnt;
    cnt_t               carry_len;
    logic               run;
    logic [N_TWIN-1:0]  gate_a;
    cnt_t               act_on_b;

    always_comb begin
        cfg_in.per  = period_len;
        cfg_in.on_a = duty_a;
        cfg_in.on_b = indep_duty ? duty_b : duty_a;
    end

    pwm_cfg_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .cfg_in    (cfg_in),
        .run       (run),
        .cnt       (cnt),
        .cfg_act   (cfg_act),
        .carry_len (carry_len),
        .pstart    (period_start)
    );

    pwm_gate_decode #(.TWINS(N_TWIN)) u_decode (
        .run       (run),
        .cnt       (cnt),
        .cfg_act   (cfg_act),
        .carry_len (carry_len),
        .gate_a    (gate_a),
        .gate_b    (gate_b)
    );

    assign gate_a0  = gate_a[0];
    assign gate_a1  = gate_a[1];
    assign act_on_b = cfg_act.on_b;

endmodule

// File: rtl/phase_pwm_chk.sv
module phase_pwm_chk
    import pwm_seq_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic en,
    input logic gate_a0,
    input logic gate_a1,
    input logic gate_b,
    input logic period_start,
    input logic run,
    input cnt_t act_on_b
);

    assert_twin_equal_R1: assert property (@(posedge clk) disable iff (rst)
        gate_a0 == gate_a1);

    assert_a_rise_at_start_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_a0) |-> period_start);

    assert_b_follows_a_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_a0) && run && !period_start && act_on_b != '0) |-> gate_b);

    assert_gates_off_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!gate_a0 && !gate_a1 && !gate_b && !period_start));

    assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
        period_start |=> !period_start);

endmodule

bind phase_pwm_top phase_pwm_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .gate_a0      (gate_a0),
    .gate_a1      (gate_a1),
    .gate_b       (gate_b),
    .period_start (period_start),
    .run          (run),
    .act_on_b     (act_on_b)
);

// File: tb/phase_pwm_top_tb_top.sv
module phase_pwm_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] period_len = 16'd20;
    logic [15:0] duty_a = 16'd0;
    logic [15:0] duty_b = 16'd0;
    logic        indep_duty = 1'b0;
    logic        gate_a0, gate_a1, gate_b, period_start;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    string tag = "R10";

    // reference model state
    int m_run = 0, m_cnt = 0, m_p = 0, m_a = 0, m_b = 0, m_carry = 0;

    always #4 clk = ~clk;

    phase_pwm_top dut_i (
        .clk(clk), .rst(rst), .en(en),
        .period_len(period_len), .duty_a(duty_a), .duty_b(duty_b),
        .indep_duty(indep_duty),
        .gate_a0(gate_a0), .gate_a1(gate_a1), .gate_b(gate_b),
        .period_start(period_start)
    );

    function automatic int overhang(int a, int b, int p);
        return (a + b > p) ? a + b - p : 0;
    endfunction

    always @(posedge clk) begin
        int np, na, nb;
        np = (period_len < 2) ? 2 : int'(period_len);
        na = (int'(duty_a) > np) ? np : int'(duty_a);
        nb = indep_duty ? int'(duty_b) : int'(duty_a);
        if (nb > np) nb = np;
        if (rst || !en) begin
            m_run = 0; m_cnt = 0; m_p = 0; m_a = 0; m_b = 0; m_carry = 0;
        end else if (m_run == 0) begin
            m_run = 1; m_cnt = 0; m_p = np; m_a = na; m_b = nb;
            m_carry = overhang(na, nb, np);
        end else if (m_cnt == m_p - 1) begin
            m_carry = overhang(m_a, m_b, m_p);
            m_cnt = 0; m_p = np; m_a = na; m_b = nb;
        end else begin
            m_cnt++;
        end
    end

    task automatic check(string req, string what, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: got %0b expected %0b", req, what, cyc, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(negedge clk) begin
        logic ea, eb, ep;
        string tb_req;
        cyc++;
        ea = (m_run != 0) && (m_cnt < m_a);
        eb = (m_run != 0) && ((m_cnt >= m_a && m_cnt < m_a + m_b) || m_cnt < m_carry);
        ep = (m_run != 0) && (m_cnt == 0);
        tb_req = (m_cnt < m_carry) ? "R3" : "R2";
        if (!done) begin
            check({"R1/", tag}, "gate_a0", gate_a0, ea);
            check({"R1/", tag}, "gate_a1", gate_a1, ea);
            check({tb_req, "/", tag}, "gate_b", gate_b, eb);
            check({"R5/", tag}, "period_start", period_start, ep);
        end
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: got running expected finished", cyc);
            done = 1;
            finish_run();
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        step(4);
        rst = 0;
        // R1 R2: no spill, independent duties
        tag = "R2"; indep_duty = 1; duty_a = 10; duty_b = 6; en = 1;
        step(62);
        // R3: spill of 6 cycles, change mid-period (R6)
        tag = "R3"; duty_a = 12; duty_b = 14;
        step(65);
        tag = "R6"; duty_a = 16; duty_b = 8;
        step(7);
        period_len = 24;
        step(50);
        // R4: single-duty mode ignores duty_b
        tag = "R4"; period_len = 20; indep_duty = 0; duty_a = 15; duty_b = 3;
        step(63);
        // R8: zero and full-scale duty
        tag = "R8"; duty_a = 0;
        step(45);
        duty_a = 30;
        step(45);
        indep_duty = 1; duty_a = 20; duty_b = 0;
        step(45);
        // R9: disable mid-period, then R7 restart with spill in first period
        tag = "R9"; duty_a = 14; duty_b = 14;
        step(9);
        en = 0;
        step(5);
        tag = "R7"; en = 1;
        step(50);
        // R5: short periods, including below minimum
        tag = "R5"; period_len = 7; duty_a = 4; duty_b = 5;
        step(30);
        period_len = 1; duty_a = 1; duty_b = 2;
        step(12);
        // R10: reset in the middle of a run
        tag = "R10"; rst = 1;
        step(3);
        rst = 0; en = 0;
        step(3);
        done = 1;
        finish_run();
    end

endmodule